// File: doc/BRIEF.md
# Edge Discriminator with Holdoff

This block watches a stream of signed 14-bit ADC samples, one per clock, and raises a single-cycle fire strobe when it recognises a signal edge. Two detection methods are available. The slope method compares the difference between the newest sample and a sample K steps older against a threshold. The constant-fraction method builds a bipolar signal from a delayed sample minus a shift-and-add fraction of the current sample. It fires on that signal's zero crossing once an arming level has been passed. Each method can be told to respond to rising edges, falling edges or both.

When it fires, the block captures the timestamp that accompanied the triggering sample. It keeps the timestamp of the previous firing beside it, so a downstream event builder can report both. It also reports whether the edge was rising or falling. A programmable holdoff then blocks further fires for a number of samples, so one physical edge produces one fire. Holdoff values of a few tens of samples and below are supported, so the block re-arms fast enough for event rates above 1 MHz at 100 MS/s.

Top module: `edge_disc`

## Requirements
- R1: While reset is held and directly after it, `fire_o`, `fire_ts_o`, `prev_ts_o` and `fire_neg_o` are all zero.
- R2: Slope mode (`cfg_mode_i` = 0) forms d[n] = x[n] - x[n-K], where K = `cfg_led_k_i`. A rising candidate occurs when d[n] >= T and d[n-1] < T, where T = `cfg_thr_i` is unsigned and positive. A falling candidate occurs when d[n] <= -T and d[n-1] > -T. Equality with the threshold counts as reaching it.
- R3: Constant-fraction mode (`cfg_mode_i` = 1) forms y[n] = x[n-D] - F(x[n]), where D = `cfg_cfd_dly_i`. F is the sum of arithmetic right shifts of x[n] chosen by `cfg_frac_i`: bit 2 adds x>>>1, bit 1 adds x>>>2 and bit 0 adds x>>>3.
- R4: In constant-fraction mode, a sample with y <= -A arms the rising side, where A = `cfg_arm_i`. A later sample with y >= 0 is a rising candidate and clears that arm. A sample with y >= A arms the falling side. A later sample with y < 0 is a falling candidate and clears that arm. If the arming level is never reached, the block does not fire.
- R5: `cfg_pol_i` bit 0 enables rising candidates and bit 1 enables falling ones. A disabled candidate causes no fire and leaves all timestamp and polarity outputs unchanged.
- R6: A fire is a one-cycle pulse on `fire_o`. It is high in the clock cycle after the second rising edge that follows the triggering sample's presentation, i.e. one register stage after the sample enters the delay line.
- R7: A fire loads a holdoff count H = `cfg_holdoff_i`. Candidates from the next H samples are ignored, so two fires are at least H+1 samples apart. With H = 0, fires may occur on consecutive cycles.
- R8: On a fire, `fire_ts_o` takes the `ts_i` value that was presented with the triggering sample and holds it until the next fire.
- R9: On a fire, `prev_ts_o` takes the value `fire_ts_o` had before that fire.
- R10: On a fire, `fire_neg_o` becomes 1 for a falling edge and 0 for a rising edge, and holds until the next fire.
- R11: Only the mode selected by `cfg_mode_i` can produce a fire. Candidates of the other method have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 14 | Signed ADC sample |
| ts_i | input | 48 | Timestamp accompanying the sample |
| cfg_mode_i | input | 1 | 0 slope, 1 constant fraction |
| cfg_pol_i | input | 2 | Bit 0 rising enable, bit 1 falling enable |
| cfg_led_k_i | input | 4 | Slope look-back distance K |
| cfg_thr_i | input | 14 | Slope threshold magnitude |
| cfg_cfd_dly_i | input | 4 | Constant-fraction delay D |
| cfg_frac_i | input | 3 | Fraction shift-and-add select |
| cfg_arm_i | input | 14 | Constant-fraction arming level |
| cfg_holdoff_i | input | 8 | Holdoff length in samples |
| fire_o | output | 1 | One-cycle fire strobe |
| fire_ts_o | output | 48 | Timestamp of the latest fire |
| prev_ts_o | output | 48 | Timestamp of the fire before it |
| fire_neg_o | output | 1 | Polarity of the latest fire, 1 falling |

## Verification
A sample presented before clock edge n sits in the delay line after edge n. The decision on it is registered at edge n+1, so `fire_o` and the three captured outputs change together one cycle after that. The bench drives each sample at a falling edge and counts the samples it has pushed. It looks at the outputs at every falling edge and attributes any fire it sees to the sample two behind its counter. Each scenario therefore checks both the exact triggering sample index and the timestamp it was paired with. Holdoff checks use candidates spaced one sample apart, so they show which of them survive for H = 0, 1 and 2.

// File: rtl/edge_disc_pkg.sv
// Shared types for the edge discriminator.
// Assumes: nothing beyond IEEE 1800-2017.
package edge_disc_pkg;

    // Detection method selector.
    typedef enum logic {
        DISC_SLOPE    = 1'b0,
        DISC_FRACTION = 1'b1
    } disc_mode_e;

    // One candidate flag per edge direction.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    // Bit positions inside the polarity enable field.
    localparam int unsigned POL_RISE_BIT = 0;
    localparam int unsigned POL_FALL_BIT = 1;

endpackage

// File: rtl/edge_disc_hist.sv
// Sample delay line with two programmable taps, plus a one-stage
// timestamp register aligned with the newest sample.
// Assumes: MAX_DLY is a power of two so every tap index is in range.
module edge_disc_hist #(
    parameter int unsigned SAMPLE_W = 14,
    parameter int unsigned TS_W     = 48,
    parameter int unsigned MAX_DLY  = 16,
    localparam int unsigned DLY_W   = $clog2(MAX_DLY)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic        [TS_W-1:0]     ts_i,
    input  logic        [DLY_W-1:0]    tap_a_i,
    input  logic        [DLY_W-1:0]    tap_b_i,
    output logic signed [SAMPLE_W-1:0] now_o,
    output logic signed [SAMPLE_W-1:0] tap_a_o,
    output logic signed [SAMPLE_W-1:0] tap_b_o,
    output logic        [TS_W-1:0]     ts_o
);

    logic signed [SAMPLE_W-1:0] hist [MAX_DLY];

    // Shift the newest sample in; hist[j] holds the sample j steps old.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_DLY; i++) begin
                hist[i] <= '0;
            end
        end else begin
            hist[0] <= sample_i;
            for (int i = 1; i < MAX_DLY; i++) begin
                hist[i] <= hist[i-1];
            end
        end
    end

    // Keep the timestamp paired with hist[0].
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_o <= '0;
        end else begin
            ts_o <= ts_i;
        end
    end

    assign now_o   = hist[0];
    assign tap_a_o = hist[tap_a_i];
    assign tap_b_o = hist[tap_b_i];

endmodule

// File: rtl/edge_disc_detect.sv
// Edge candidate generation for both methods: slope crossing of a
// signed threshold, and armed zero crossing of a constant-fraction signal.
// Assumes: threshold and arming level are non-negative magnitudes.
module edge_disc_detect
    import edge_disc_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  disc_mode_e                 mode_i,
    input  logic signed [SAMPLE_W-1:0] now_i,
    input  logic signed [SAMPLE_W-1:0] slope_ref_i,
    input  logic signed [SAMPLE_W-1:0] cfd_ref_i,
    input  logic        [SAMPLE_W-1:0] thr_i,
    input  logic        [SAMPLE_W-1:0] arm_i,
    input  logic        [2:0]          frac_i,
    output edge_pair_t                 cand_o
);

    localparam int unsigned EXT = 2;
    localparam int unsigned DW  = SAMPLE_W + EXT;
    localparam logic signed [DW-1:0] ZERO = '0;

    logic signed [DW-1:0] now_x, slope_x, cfd_x;
    logic signed [DW-1:0] slope_d, slope_prev;
    logic signed [DW-1:0] sh1, sh2, sh3, frac_x, cfd_y;
    logic signed [DW-1:0] thr_p, thr_n, arm_p, arm_n;
    logic                 pos_arm, neg_arm;
    edge_pair_t           slope_c, frac_c;

    // Widen inputs with sign or zero extension.
    always_comb begin
        now_x   = {{EXT{now_i[SAMPLE_W-1]}}, now_i};
        slope_x = {{EXT{slope_ref_i[SAMPLE_W-1]}}, slope_ref_i};
        cfd_x   = {{EXT{cfd_ref_i[SAMPLE_W-1]}}, cfd_ref_i};
        thr_p   = {{EXT{1'b0}}, thr_i};
        arm_p   = {{EXT{1'b0}}, arm_i};
        thr_n   = -thr_p;
        arm_n   = -arm_p;
    end

    // Form the slope difference and the constant-fraction signal.
    always_comb begin
        slope_d = now_x - slope_x;
        sh1     = now_x >>> 1;
        sh2     = now_x >>> 2;
        sh3     = now_x >>> 3;
        frac_x  = (frac_i[2] ? sh1 : ZERO)
                + (frac_i[1] ? sh2 : ZERO)
                + (frac_i[0] ? sh3 : ZERO);
        cfd_y   = cfd_x - frac_x;
    end

    // Candidate flags of each method.
    always_comb begin
        slope_c.rise = (slope_d >= thr_p) && (slope_prev < thr_p);
        slope_c.fall = (slope_d <= thr_n) && (slope_prev > thr_n);
        frac_c.rise  = pos_arm && (cfd_y >= ZERO);
        frac_c.fall  = neg_arm && (cfd_y <  ZERO);
        cand_o       = (mode_i == DISC_FRACTION) ? frac_c : slope_c;
    end

    // Remember the last slope difference for crossing detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slope_prev <= '0;
        end else begin
            slope_prev <= slope_d;
        end
    end

    // Arm on reaching the arming level, disarm on the zero crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_arm <= 1'b0;
            neg_arm <= 1'b0;
        end else begin
            if (cfd_y >= ZERO) begin
                pos_arm <= 1'b0;
            end else if (cfd_y <= arm_n) begin
                pos_arm <= 1'b1;
            end
            if (cfd_y < ZERO) begin
                neg_arm <= 1'b0;
            end else if (cfd_y >= arm_p) begin
                neg_arm <= 1'b1;
            end
        end
    end

    // R2 / R4: one sample can never be both a rising and a falling candidate.
    a_r4_cand_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cand_o.rise && cand_o.fall));

endmodule

// File: rtl/edge_disc_holdoff.sv
// Polarity masking, holdoff gating and capture of the fire timestamps.
// Assumes: ts_i is the timestamp of the sample whose candidates arrive.
module edge_disc_holdoff
    import edge_disc_pkg::*;
#(
    parameter int unsigned TS_W   = 48,
    parameter int unsigned HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  edge_pair_t        cand_i,
    input  logic [1:0]        pol_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    input  logic [TS_W-1:0]   ts_i,
    output logic              fire_o,
    output logic [TS_W-1:0]   fire_ts_o,
    output logic [TS_W-1:0]   prev_ts_o,
    output logic              fire_neg_o
);

    logic [HOLD_W-1:0] hcnt;
    logic              rise_ok, fall_ok, idle, take;

    // Apply the polarity mask and the holdoff gate.
    always_comb begin
        rise_ok = cand_i.rise && pol_i[POL_RISE_BIT];
        fall_ok = cand_i.fall && pol_i[POL_FALL_BIT];
        idle    = (hcnt == '0);
        take    = (rise_ok || fall_ok) && idle;
    end

    // Register the fire, load or count down holdoff, capture timestamps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_o     <= 1'b0;
            hcnt       <= '0;
            fire_ts_o  <= '0;
            prev_ts_o  <= '0;
            fire_neg_o <= 1'b0;
        end else begin
            fire_o <= take;
            if (take) begin
                hcnt       <= holdoff_i;
                fire_ts_o  <= ts_i;
                prev_ts_o  <= fire_ts_o;
                fire_neg_o <= fall_ok && !rise_ok;
            end else if (!idle) begin
                hcnt <= hcnt - 1'b1;
            end
        end
    end

    // R7: a nonzero holdoff forbids a fire in the very next cycle.
    a_r7_holdoff_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && (holdoff_i != '0)) |=> !fire_o);

    // R8: the fire timestamp only moves together with a fire.
    a_r8_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_o |-> $stable(fire_ts_o));

    // R9: the previous timestamp is the one reported before this fire.
    a_r9_prev_chain: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> (prev_ts_o == $past(fire_ts_o)));

    // R5: a disabled direction never shows up as the reported polarity.
    a_r5_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !pol_i[POL_FALL_BIT]) |-> !fire_neg_o);
    a_r5_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !pol_i[POL_RISE_BIT]) |-> fire_neg_o);

endmodule

// File: rtl/edge_disc.sv
// Edge discriminator top: delay line, candidate detection, and holdoff
// gating with timestamp capture. One sample per clock.
// Assumes: configuration is held steady while samples flow.
module edge_disc
    import edge_disc_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 14,
    parameter int unsigned TS_W     = 48,
    parameter int unsigned MAX_DLY  = 16,
    parameter int unsigned HOLD_W   = 8,
    localparam int unsigned DLY_W   = $clog2(MAX_DLY)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [TS_W-1:0]     ts_i,
    input  logic                cfg_mode_i,
    input  logic [1:0]          cfg_pol_i,
    input  logic [DLY_W-1:0]    cfg_led_k_i,
    input  logic [SAMPLE_W-1:0] cfg_thr_i,
    input  logic [DLY_W-1:0]    cfg_cfd_dly_i,
    input  logic [2:0]          cfg_frac_i,
    input  logic [SAMPLE_W-1:0] cfg_arm_i,
    input  logic [HOLD_W-1:0]   cfg_holdoff_i,
    output logic                fire_o,
    output logic [TS_W-1:0]     fire_ts_o,
    output logic [TS_W-1:0]     prev_ts_o,
    output logic                fire_neg_o
);

    logic signed [SAMPLE_W-1:0] s_now, s_slope, s_cfd;
    logic        [TS_W-1:0]     ts_al;
    edge_pair_t                 cand;
    disc_mode_e                 mode;

    assign mode = disc_mode_e'(cfg_mode_i);

    edge_disc_hist #(
        .SAMPLE_W (SAMPLE_W),
        .TS_W     (TS_W),
        .MAX_DLY  (MAX_DLY)
    ) i_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i ($signed(sample_i)),
        .ts_i     (ts_i),
        .tap_a_i  (cfg_led_k_i),
        .tap_b_i  (cfg_cfd_dly_i),
        .now_o    (s_now),
        .tap_a_o  (s_slope),
        .tap_b_o  (s_cfd),
        .ts_o     (ts_al)
    );

    edge_disc_detect #(
        .SAMPLE_W (SAMPLE_W)
    ) i_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .now_i       (s_now),
        .slope_ref_i (s_slope),
        .cfd_ref_i   (s_cfd),
        .thr_i       (cfg_thr_i),
        .arm_i       (cfg_arm_i),
        .frac_i      (cfg_frac_i),
        .cand_o      (cand)
    );

    edge_disc_holdoff #(
        .TS_W   (TS_W),
        .HOLD_W (HOLD_W)
    ) i_holdoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_i     (cand),
        .pol_i      (cfg_pol_i),
        .holdoff_i  (cfg_holdoff_i),
        .ts_i       (ts_al),
        .fire_o     (fire_o),
        .fire_ts_o  (fire_ts_o),
        .prev_ts_o  (prev_ts_o),
        .fire_neg_o (fire_neg_o)
    );

endmodule

// File: tb/test_edge_disc.sv
// Directed bench for edge_disc: one task per scenario, each checking itself.
module test_edge_disc;

    localparam longint TS_BASE = 64'h0000_A500_0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] sample_i = '0;
    logic [47:0] ts_i = '0;
    logic        cfg_mode_i = 1'b0;
    logic [1:0]  cfg_pol_i = 2'b01;
    logic [3:0]  cfg_led_k_i = 4'd2;
    logic [13:0] cfg_thr_i = 14'd100;
    logic [3:0]  cfg_cfd_dly_i = 4'd4;
    logic [2:0]  cfg_frac_i = 3'b100;
    logic [13:0] cfg_arm_i = 14'd100;
    logic [7:0]  cfg_holdoff_i = 8'd3;
    logic        fire_o;
    logic [47:0] fire_ts_o;
    logic [47:0] prev_ts_o;
    logic        fire_neg_o;

    int     n_run = 0;
    int     n_fail = 0;
    int     smp_idx = 0;
    int     nfire = 0;
    int     log_idx [32];
    longint log_ts [32];
    longint log_prev [32];
    bit     log_neg [32];
    bit     done = 1'b0;

    always #5 clk = ~clk;

    edge_disc i_edge_disc (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_i      (sample_i),
        .ts_i          (ts_i),
        .cfg_mode_i    (cfg_mode_i),
        .cfg_pol_i     (cfg_pol_i),
        .cfg_led_k_i   (cfg_led_k_i),
        .cfg_thr_i     (cfg_thr_i),
        .cfg_cfd_dly_i (cfg_cfd_dly_i),
        .cfg_frac_i    (cfg_frac_i),
        .cfg_arm_i     (cfg_arm_i),
        .cfg_holdoff_i (cfg_holdoff_i),
        .fire_o        (fire_o),
        .fire_ts_o     (fire_ts_o),
        .prev_ts_o     (prev_ts_o),
        .fire_neg_o    (fire_neg_o)
    );

    // Record every observed fire, attributed to the sample two behind.
    always @(negedge clk) begin
        if (rst_n && fire_o && nfire < 32) begin
            log_idx[nfire]  = smp_idx - 2;
            log_ts[nfire]   = longint'(fire_ts_o);
            log_prev[nfire] = longint'(prev_ts_o);
            log_neg[nfire]  = fire_neg_o;
            nfire++;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input bit mode, input bit [1:0] pol, input int k,
                           input int thr, input int d, input bit [2:0] frac,
                           input int arm, input int h);
        cfg_mode_i    = mode;
        cfg_pol_i     = pol;
        cfg_led_k_i   = 4'(k);
        cfg_thr_i     = 14'(thr);
        cfg_cfd_dly_i = 4'(d);
        cfg_frac_i    = frac;
        cfg_arm_i     = 14'(arm);
        cfg_holdoff_i = 8'(h);
    endtask

    // Reset for three edges; returns at a falling edge, ready to push.
    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        sample_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n   = 1'b1;
        smp_idx = 0;
        nfire   = 0;
    endtask

    task automatic push(input int s);
        sample_i = 14'(s);
        ts_i     = 48'(TS_BASE + longint'(smp_idx));
        @(posedge clk);
        smp_idx++;
        @(negedge clk);
    endtask

    task automatic pushn(input int s, input int n);
        for (int i = 0; i < n; i++) push(s);
    endtask

    // Check fire number k: sample index, polarity, timestamp, previous.
    task automatic chk_fire(input string tag, input int k, input int idx,
                            input bit neg, input longint prev);
        if (k >= nfire) begin
            chk({tag, " fire missing"}, nfire, k + 1);
        end else begin
            chk({tag, " index R6"}, log_idx[k], idx);
            chk({tag, " polarity R10"}, log_neg[k], neg);
            chk({tag, " timestamp R8"}, log_ts[k], TS_BASE + longint'(idx));
            chk({tag, " previous R9"}, log_prev[k], prev);
        end
    endtask

    task automatic t_reset();
        set_cfg(1'b0, 2'b11, 2, 100, 4, 3'b100, 100, 3);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 fire in reset", fire_o, 0);
        do_reset();
        chk("R1 fire after reset", fire_o, 0);
        chk("R1 fire_ts after reset", longint'(fire_ts_o), 0);
        chk("R1 prev_ts after reset", longint'(prev_ts_o), 0);
        chk("R1 polarity after reset", fire_neg_o, 0);
    endtask

    // Slope step up at 8 and down at 18; CFD settings would fire at 12 (R11).
    task automatic t_led_step(input bit [1:0] pol);
        int     k;
        longint prev;
        set_cfg(1'b0, pol, 2, 100, 4, 3'b100, 100, 3);
        do_reset();
        pushn(0, 8); pushn(500, 10); pushn(0, 12);
        chk($sformatf("R2 R5 R11 slope step fire count pol=%0d", pol), nfire,
            int'(pol[0]) + int'(pol[1]));
        k = 0; prev = 0;
        if (pol[0]) begin
            chk_fire("R2 slope rise", k, 8, 1'b0, prev);
            prev = TS_BASE + 8; k++;
        end
        if (pol[1]) begin
            chk_fire("R2 slope fall", k, 18, 1'b1, prev);
        end
        if (pol == 2'b01) begin
            chk("R5 masked fall keeps timestamp", longint'(fire_ts_o), TS_BASE + 8);
            chk("R5 masked fall keeps polarity", fire_neg_o, 0);
        end
    endtask

    // Ramp of 30 per sample from index 8; K and threshold decide the fire.
    task automatic t_led_ramp(input int k, input int thr, input bit exp_fire);
        set_cfg(1'b0, 2'b11, k, thr, 4, 3'b100, 100, 3);
        do_reset();
        pushn(0, 8);
        for (int j = 0; j < 20; j++) push(30 * (j + 1));
        pushn(600, 12);
        chk($sformatf("R2 ramp K=%0d thr=%0d count", k, thr), nfire, int'(exp_fire));
        if (exp_fire) chk_fire("R2 ramp", 0, 11, 1'b0, 0);
    endtask

    // Alternating 300/0 from index 8 gives a candidate on every sample 8..13.
    task automatic t_hold(input int h, input int exp_n, input int idx2, input bit neg2);
        set_cfg(1'b0, 2'b11, 1, 100, 4, 3'b100, 100, h);
        do_reset();
        pushn(0, 8);
        for (int j = 0; j < 3; j++) begin
            push(300); push(0);
        end
        pushn(0, 12);
        chk($sformatf("R7 holdoff=%0d fire count", h), nfire, exp_n);
        chk_fire("R7 first", 0, 8, 1'b0, 0);
        chk_fire($sformatf("R7 second holdoff=%0d", h), 1, idx2, neg2, TS_BASE + 8);
    endtask

    // CFD positive step of amp from index 8, delay 4, rising only.
    task automatic t_cfd_pos(input bit [2:0] frac, input int amp, input bit exp_fire);
        set_cfg(1'b1, 2'b01, 2, 100, 4, frac, 100, 3);
        do_reset();
        pushn(0, 8); pushn(amp, 16); pushn(0, 16);
        chk($sformatf("R3 R4 R11 cfd frac=%0d amp=%0d count", frac, amp), nfire,
            int'(exp_fire));
        if (exp_fire) chk_fire("R3 R4 cfd rise", 0, 12, 1'b0, 0);
    endtask

    // CFD negative pulse: falling fire at 12, rising fire on return at 28.
    task automatic t_cfd_neg();
        set_cfg(1'b1, 2'b11, 2, 100, 4, 3'b100, 100, 3);
        do_reset();
        pushn(0, 8); pushn(-800, 16); pushn(0, 16);
        chk("R4 cfd bipolar count", nfire, 2);
        chk_fire("R4 cfd fall", 0, 12, 1'b1, 0);
        chk_fire("R4 cfd return rise", 1, 28, 1'b0, TS_BASE + 12);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_led_step(2'b01);
        t_led_step(2'b11);
        t_led_step(2'b10);
        t_led_ramp(4, 100, 1'b1);
        t_led_ramp(2, 100, 1'b0);
        t_led_ramp(4, 120, 1'b1);
        t_led_ramp(4, 121, 1'b0);
        t_hold(0, 6, 9, 1'b1);
        t_hold(1, 3, 10, 1'b0);
        t_hold(2, 2, 11, 1'b1);
        t_cfd_pos(3'b100, 800, 1'b1);
        t_cfd_pos(3'b010, 800, 1'b1);
        t_cfd_pos(3'b100, 150, 1'b0);
        t_cfd_pos(3'b111, 150, 1'b1);
        t_cfd_neg();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule